// File: doc/BRIEF.md
# Processor Status Word and Interrupt Gate

This block keeps the flag byte of a small 8-bit processor core: interrupt enable, zero, nibble carry, carry, an in-service priority flag and a two-bit register-bank field. The core's execute stage sends it several things:

- ALU results, with carry and nibble-carry indications.
- Rotate shift-out bits and single-bit operation results.
- Strobes for enable-interrupt, disable-interrupt and bank-select instructions.
- A full load of the status byte.

The block returns the packed status byte and the current bank number.

The same block decides whether an interrupt may be taken. From the per-source request, mask and priority vectors and a non-maskable request, it combinationally presents a grant: its validity, whether it is the non-maskable one, and the index of the chosen maskable source. The sequencer pulses an acknowledge when it takes the grant. The acknowledge closes the interrupt enable flag. It also raises the service level, so that low-priority sources cannot nest.

Top module: `psw_irq_gate`

## Requirements
- R1: After reset the status byte reads 8'h02 (only the in-service priority flag set), the bank output is 0, and no maskable grant is given.
- R2: Status byte layout is bit7 enable, bit6 zero, bit5 bank high bit, bit4 nibble carry, bit3 bank low bit, bit2 always 0, bit1 in-service priority, bit0 carry. A full load writes every bit except bit2, and it overrides all other updates in the same cycle.
- R3: An enable-interrupt strobe sets the enable flag. A disable-interrupt strobe clears it, and disable wins when both strobes arrive together.
- R4: An ALU update sets the zero flag exactly when the result is all zeros. It copies the nibble-carry input to the nibble carry flag and the carry input to the carry flag. Without an ALU update, zero and nibble carry hold.
- R5: The carry flag takes its next value from the first active source in this order: single-bit write, rotate shift-out, ALU carry.
- R6: A bank-select strobe loads the two-bit bank field, and the bank output always equals {bit5, bit3} of the status byte.
- R7: With the enable flag at 0 no maskable source is granted, while a non-maskable request is still granted.
- R8: A maskable source is eligible when it requests, its mask bit is 0 (1 = masked) and the enable flag is 1. If its priority bit is 1 (low), it also needs the in-service priority flag at 1.
- R9: The non-maskable request wins over all maskable ones. Among eligible maskable sources, high priority (priority bit 0) wins over low, and then the lowest index wins.
- R10: An acknowledge while a grant is valid clears the enable flag on the next cycle. A maskable grant also clears the in-service priority flag, and a non-maskable grant leaves it unchanged. An acknowledge with no valid grant has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_upd | input | 1 | ALU result update strobe |
| alu_result | input | DATA_W | ALU result for the zero test |
| alu_carry | input | 1 | Carry or borrow out of the operation |
| alu_nib_carry | input | 1 | Carry out of bit 3 or borrow into bit 3 |
| rot_upd | input | 1 | Rotate strobe |
| rot_bit | input | 1 | Bit shifted out by the rotate |
| bit_wr | input | 1 | Single-bit write to the carry flag |
| bit_val | input | 1 | Value for the single-bit write |
| ei_strobe | input | 1 | Enable-interrupt instruction |
| di_strobe | input | 1 | Disable-interrupt instruction |
| bank_strobe | input | 1 | Bank-select instruction |
| bank_sel | input | 2 | New bank number |
| psw_load | input | 1 | Full status byte load strobe |
| psw_load_val | input | 8 | Value for the full load |
| irq_req | input | N_SRC | Maskable requests |
| irq_mask | input | N_SRC | Mask bits, 1 = masked |
| irq_prio | input | N_SRC | Priority bits, 1 = low |
| nmi_req | input | 1 | Non-maskable request |
| irq_ack | input | 1 | Acknowledge of the presented grant |
| psw | output | 8 | Packed status byte |
| bank | output | 2 | Selected register bank |
| grant_valid | output | 1 | An interrupt may be accepted |
| grant_nmi | output | 1 | The grant is the non-maskable request |
| grant_id | output | ID_W | Index of the granted maskable source |

## Verification
The grant outputs are combinational from the current flags and the request inputs, so they are due in the same cycle. The bench checks them one time step after it drives the request vectors, with no clock edge in between. Every flag update comes from one register stage and shows on `psw` and `bank` after the next rising edge. The bench drives strobes just after an edge, lets one edge pass, removes the strobes and then samples. This includes the acknowledge, whose effect is measured against the grant that was presented before that edge.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W  = 8;
  localparam int B_IE   = 7;
  localparam int B_Z    = 6;
  localparam int B_RB1  = 5;
  localparam int B_AC   = 4;
  localparam int B_RB0  = 3;
  localparam int B_ISP  = 1;
  localparam int B_CY   = 0;

  typedef struct packed {
    logic       ie;
    logic       z;
    logic       ac;
    logic       isp;
    logic       cy;
    logic [1:0] bank;
  } flags_t;

  function automatic logic [PSW_W-1:0] pack_psw(input flags_t f);
    logic [PSW_W-1:0] v;
    v        = '0;
    v[B_IE]  = f.ie;
    v[B_Z]   = f.z;
    v[B_RB1] = f.bank[1];
    v[B_AC]  = f.ac;
    v[B_RB0] = f.bank[0];
    v[B_ISP] = f.isp;
    v[B_CY]  = f.cy;
    return v;
  endfunction

  function automatic flags_t unpack_psw(input logic [PSW_W-1:0] v);
    flags_t f;
    f.ie   = v[B_IE];
    f.z    = v[B_Z];
    f.bank = {v[B_RB1], v[B_RB0]};
    f.ac   = v[B_AC];
    f.isp  = v[B_ISP];
    f.cy   = v[B_CY];
    return f;
  endfunction

  localparam flags_t FLAGS_RST = '{ie: 1'b0, z: 1'b0, ac: 1'b0, isp: 1'b1, cy: 1'b0, bank: 2'd0};
endpackage

// File: rtl/psw_flags.sv
module psw_flags
  import psw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_upd,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_nib_carry,
  input  logic              rot_upd,
  input  logic              rot_bit,
  input  logic              bit_wr,
  input  logic              bit_val,
  input  logic              ei_strobe,
  input  logic              di_strobe,
  input  logic              bank_strobe,
  input  logic [1:0]        bank_sel,
  input  logic              psw_load,
  input  logic [PSW_W-1:0]  psw_load_val,
  input  logic              ack_take,
  input  logic              ack_maskable,
  output flags_t            flags
);
  flags_t nxt;
  logic   result_zero;
  logic   unused_rsvd;

  assign result_zero = ~|alu_result;
  assign unused_rsvd = psw_load_val[2];

  always_comb begin
    nxt = flags;
    if (alu_upd) begin
      nxt.z  = result_zero;
      nxt.ac = alu_nib_carry;
      nxt.cy = alu_carry;
    end
    if (rot_upd)      nxt.cy   = rot_bit;
    if (bit_wr)       nxt.cy   = bit_val;
    if (bank_strobe)  nxt.bank = bank_sel;
    if (ei_strobe)    nxt.ie   = 1'b1;
    if (di_strobe || ack_take) nxt.ie = 1'b0;
    if (ack_maskable) nxt.isp  = 1'b0;
    if (psw_load)     nxt      = unpack_psw(psw_load_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= FLAGS_RST;
    else        flags <= nxt;
  end

  a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    psw_load |=> (pack_psw(flags) == ($past(psw_load_val) & 8'hFB)));
  a_r3_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (di_strobe && !psw_load) |=> !flags.ie);
  a_r5_bit_wr_first: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr && !psw_load) |=> (flags.cy == $past(bit_val)));
  a_r10_ack_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !psw_load) |=> !flags.ie);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_SRC = 8,
  localparam int ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_mask,
  input  logic [N_SRC-1:0] irq_prio,
  input  logic             nmi_req,
  input  logic             ie,
  input  logic             isp,
  output logic             grant_valid,
  output logic             grant_nmi,
  output logic [ID_W-1:0]  grant_id
);
  logic [N_SRC-1:0] elig_hi, elig_lo;
  logic             any_hi, any_lo;
  logic [ID_W-1:0]  id_hi, id_lo;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic open;
    assign open       = irq_req[g] & ~irq_mask[g] & ie;
    assign elig_hi[g] = open & ~irq_prio[g];
    assign elig_lo[g] = open &  irq_prio[g] & isp;
  end

  always_comb begin
    id_hi = '0;
    id_lo = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig_hi[i]) id_hi = ID_W'(i);
      if (elig_lo[i]) id_lo = ID_W'(i);
    end
  end

  assign any_hi      = |elig_hi;
  assign any_lo      = |elig_lo;
  assign grant_nmi   = nmi_req;
  assign grant_valid = nmi_req | any_hi | any_lo;
  assign grant_id    = any_hi ? id_hi : id_lo;

  a_r7_closed_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie && grant_valid) |-> grant_nmi);
  a_r8_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_nmi) |-> (irq_req[grant_id] && !irq_mask[grant_id]));
  a_r8_isp_blocks_low: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_nmi && !isp) |-> !irq_prio[grant_id]);
  a_r9_high_first: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_nmi && any_hi) |-> !irq_prio[grant_id]);
endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate
  import psw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_SRC  = 8,
  localparam int ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_upd,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_nib_carry,
  input  logic              rot_upd,
  input  logic              rot_bit,
  input  logic              bit_wr,
  input  logic              bit_val,
  input  logic              ei_strobe,
  input  logic              di_strobe,
  input  logic              bank_strobe,
  input  logic [1:0]        bank_sel,
  input  logic              psw_load,
  input  logic [7:0]        psw_load_val,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic [N_SRC-1:0]  irq_mask,
  input  logic [N_SRC-1:0]  irq_prio,
  input  logic              nmi_req,
  input  logic              irq_ack,
  output logic [7:0]        psw,
  output logic [1:0]        bank,
  output logic              grant_valid,
  output logic              grant_nmi,
  output logic [ID_W-1:0]   grant_id
);
  flags_t flags;
  logic   ack_take, ack_maskable;

  assign ack_take     = irq_ack & grant_valid;
  assign ack_maskable = ack_take & ~grant_nmi;

  psw_flags #(.DATA_W(DATA_W)) u_flags (
    .clk, .rst_n, .alu_upd, .alu_result, .alu_carry, .alu_nib_carry,
    .rot_upd, .rot_bit, .bit_wr, .bit_val, .ei_strobe, .di_strobe,
    .bank_strobe, .bank_sel, .psw_load, .psw_load_val,
    .ack_take, .ack_maskable, .flags
  );

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .clk, .rst_n, .irq_req, .irq_mask, .irq_prio, .nmi_req,
    .ie(flags.ie), .isp(flags.isp),
    .grant_valid, .grant_nmi, .grant_id
  );

  assign psw  = pack_psw(flags);
  assign bank = flags.bank;

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n) !psw[2]);
  a_r9_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (grant_valid && grant_nmi));
  a_r10_nmi_keeps_isp: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && grant_nmi && !psw_load) |=> (psw[1] == $past(psw[1])));
endmodule

// File: tb/psw_irq_gate_tb.sv
module psw_irq_gate_tb;
  localparam int N_SRC = 8;
  localparam int ID_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alu_upd = 0, alu_carry = 0, alu_nib_carry = 0, rot_upd = 0, rot_bit = 0;
  logic bit_wr = 0, bit_val = 0, ei_strobe = 0, di_strobe = 0, bank_strobe = 0;
  logic psw_load = 0, nmi_req = 0, irq_ack = 0;
  logic [7:0] alu_result = 0, psw_load_val = 0;
  logic [1:0] bank_sel = 0;
  logic [N_SRC-1:0] irq_req = 0, irq_mask = 0, irq_prio = 0;
  logic [7:0] psw;
  logic [1:0] bank;
  logic grant_valid, grant_nmi;
  logic [ID_W-1:0] grant_id;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  psw_irq_gate u_dut (.*);

  typedef struct packed {
    logic       au;
    logic [7:0] res;
    logic       c;
    logic       n;
    logic       ru;
    logic       rb;
    logic       bw;
    logic       bv;
    logic [7:0] exp_psw;
  } vec_t;

  // expected psw = {0, Z, 0, AC, 0, 0, ISP=1, CY}
  localparam vec_t TBL [7] = '{
    '{1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h43},
    '{1'b1, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h12},
    '{1'b1, 8'h80, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h12},
    '{1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h42},
    '{1'b0, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h43},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h42},
    '{1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    alu_upd = 0; rot_upd = 0; bit_wr = 0; ei_strobe = 0; di_strobe = 0;
    bank_strobe = 0; psw_load = 0; irq_ack = 0;
  endtask

  task automatic load(input logic [7:0] v);
    psw_load = 1; psw_load_val = v;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 reset psw", psw, 8'h02);
    chk("R1 reset bank", {6'd0, bank}, 8'h00);
    irq_req = 8'h01;
    #1 chk("R1 no maskable grant", {7'd0, grant_valid}, 8'h00);
    irq_req = 0;

    for (int k = 0; k < 7; k++) begin
      alu_upd = TBL[k].au; alu_result = TBL[k].res; alu_carry = TBL[k].c;
      alu_nib_carry = TBL[k].n; rot_upd = TBL[k].ru; rot_bit = TBL[k].rb;
      bit_wr = TBL[k].bw; bit_val = TBL[k].bv;
      tick();
      chk("R4 R5 flag vector", psw, TBL[k].exp_psw);
    end

    ei_strobe = 1; tick();
    chk("R3 EI sets", psw & 8'h80, 8'h80);
    di_strobe = 1; tick();
    chk("R3 DI clears", psw & 8'h80, 8'h00);
    ei_strobe = 1; di_strobe = 1; tick();
    chk("R3 DI wins over EI", psw & 8'h80, 8'h00);

    bank_strobe = 1; bank_sel = 2'd3; tick();
    chk("R6 bank 3 bits", psw & 8'h28, 8'h28);
    chk("R6 bank 3 out", {6'd0, bank}, 8'h03);
    bank_strobe = 1; bank_sel = 2'd2; tick();
    chk("R6 bank 2 bits", psw & 8'h28, 8'h20);
    chk("R6 bank 2 out", {6'd0, bank}, 8'h02);

    load(8'hFF);
    chk("R2 load all, bit2 zero", psw, 8'hFB);
    chk("R2 R6 bank after load", {6'd0, bank}, 8'h03);
    ei_strobe = 1; alu_upd = 1; alu_result = 8'h00; alu_carry = 1;
    bank_strobe = 1; bank_sel = 2'd3;
    load(8'h00);
    chk("R2 load overrides updates", psw, 8'h00);

    irq_req = 8'h04; irq_mask = 0; irq_prio = 0;
    #1 chk("R7 IE=0 blocks maskable", {7'd0, grant_valid}, 8'h00);
    nmi_req = 1;
    #1 chk("R7 nmi with IE=0", {6'd0, grant_valid, grant_nmi}, 8'h03);
    nmi_req = 0;

    load(8'h82);
    irq_req = 8'h06; irq_prio = 8'h02;
    #1 chk("R9 high before low", {4'd0, grant_valid, grant_id}, 8'h0A);
    irq_mask = 8'h04;
    #1 chk("R8 mask, low ok with ISP=1", {4'd0, grant_valid, grant_id}, 8'h09);
    nmi_req = 1;
    #1 chk("R9 nmi wins", {6'd0, grant_valid, grant_nmi}, 8'h03);
    nmi_req = 0;
    load(8'h80);
    #1 chk("R8 ISP=0 blocks low", {7'd0, grant_valid}, 8'h00);
    irq_req = 8'h28; irq_mask = 0; irq_prio = 0;
    #1 chk("R9 lowest index", {4'd0, grant_valid, grant_id}, 8'h0B);
    irq_ack = 1; tick();
    chk("R10 ack high", psw, 8'h00);

    load(8'h82);
    irq_req = 8'h02; irq_prio = 8'h02;
    #1 chk("R8 low granted", {4'd0, grant_valid, grant_id}, 8'h09);
    irq_ack = 1; tick();
    chk("R10 ack low clears ISP", psw, 8'h00);

    load(8'h82);
    irq_req = 0;
    irq_ack = 1; tick();
    chk("R10 ack without grant ignored", psw, 8'h82);
    nmi_req = 1; irq_ack = 1; tick();
    chk("R10 nmi ack keeps ISP", psw, 8'h02);
    nmi_req = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule